// File: doc/BRIEF.md
# Owner-Steering Page Translation Buffer

This block is a small, fully associative translation buffer for a processing core placed beside memory. Each cached entry maps one 2 MiB virtual page to a physical page. Each entry also records a software-chosen owner: the one cache in the system allowed to hold that page's data. Owner value zero stands for the host processor's cache hierarchy, and values 1 to 63 name memory-side core caches.

For every load, store or instruction fetch, the buffer translates the address and checks the requested kind of access against the page's read, write and execute bits. It then returns a steering decision: the owner to forward the request to, whether that owner is the issuing core's own cache, and whether the returned line may be allocated locally. It also returns the memory partition to use if the owner misses, which is taken from the physical page bits just above the page offset. A lookup that finds no entry is not walked here. It is raised to a handler on the host, which answers with either a translation or an abort. Software can retarget the owner of a cached page, and can invalidate the whole buffer in one cycle.

The control is a three-state machine:
- IDLE accepts a request.
- WAIT holds an outstanding miss.
- RESP presents a registered result until it is taken.

The transitions are:
- accept-hit: IDLE to RESP.
- accept-miss: IDLE to WAIT.
- fill-return: WAIT to RESP.
- drain: RESP to IDLE, when the result is consumed.

Top module: `otlb_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `miss_valid` are 0, and no entry is valid, so the first access to any page misses.
- R2: A request accepted while its page is cached gives `rsp_valid` exactly one cycle after acceptance. On a successful access, `rsp_paddr` equals the cached physical page number concatenated with the low 21 address bits.
- R3: A request whose page is absent raises `miss_valid` one cycle after acceptance, with `miss_vpn` set to address bits [47:21]. These stay asserted and stable until `fill_valid` arrives. The response follows one cycle after the fill, and the filled page then hits.
- R4: A fill with `fill_abort` = 1 gives `rsp_code` = 2 and installs nothing, so the same page misses again.
- R5: `req_op` encodes 0 = load, 1 = store, 2 = fetch and 3 = reserved. `perm` bit 0 grants read, bit 1 write and bit 2 execute. A load needs read, a store needs write, a fetch needs execute, and the reserved op never passes. A failed check gives `rsp_code` = 1 with `rsp_paddr`, `rsp_owner`, `rsp_local`, `rsp_cacheable`, `rsp_to_host` and `rsp_partition` all zero.
- R6: On a successful access (`rsp_code` = 0), `rsp_owner` is the page's owner. `rsp_local` is 1 exactly when the owner equals `core_id`, and `rsp_to_host` is 1 exactly when the owner is 0.
- R7: `rsp_cacheable` is 1 only for a successful access whose owner is the issuing core.
- R8: `rsp_partition` equals physical address bits [23:21].
- R9: An owner write retargets a cached page, and later hits report the new owner. An owner write for a page that is not cached changes nothing, and that page still misses.
- R10: Refills use round-robin victim selection starting at slot 0. Once all 16 slots are full, the next refill evicts the oldest page and leaves the others in place.
- R11: `inv_all` clears every entry in one cycle and returns the victim pointer to slot 0.
- R12: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds stable and `req_ready` stays 0.
- R13: A `fill_valid` pulse with no miss outstanding produces no response and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id | input | 6 | Owner value of the issuing core's own cache |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Buffer can accept a request |
| req_vaddr | input | 48 | Virtual address |
| req_op | input | 2 | Access kind |
| miss_valid | output | 1 | Miss raised to the host handler |
| miss_vpn | output | 27 | Virtual page of the outstanding miss |
| fill_valid | input | 1 | Handler answer present |
| fill_ppn | input | 19 | Physical page returned |
| fill_perm | input | 3 | Permission bits returned |
| fill_owner | input | 6 | Owner returned |
| fill_abort | input | 1 | Handler terminates the access |
| own_wr_valid | input | 1 | Software owner write strobe |
| own_wr_vpn | input | 27 | Page to retarget |
| own_wr_owner | input | 6 | New owner value |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_code | output | 2 | 0 route, 1 permission fault, 2 abort |
| rsp_paddr | output | 40 | Translated physical address |
| rsp_owner | output | 6 | Cache to forward to |
| rsp_local | output | 1 | Owner is the issuing core |
| rsp_cacheable | output | 1 | Line may be allocated locally |
| rsp_to_host | output | 1 | Owner is the host hierarchy |
| rsp_partition | output | 3 | Memory partition for an owner miss |

## Verification
The checker assumes that `core_id` is nonzero and constant, and that `fill_valid` is pulsed only for one cycle. It also assumes that the consumer keeps `rsp_ready` low for as long as it wishes to stall. The bench drives all inputs at the falling edge and keeps `core_id` at 5. It pulses fill, owner-write and invalidate strobes for exactly one cycle, and never presents a request unless `req_ready` is high. Because of this, every clocked property sees only legal handshake sequences.

// File: rtl/otlb_pkg.sv
package otlb_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FETCH = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RC_ROUTE = 2'd0,
        RC_FAULT = 2'd1,
        RC_ABORT = 2'd2
    } code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;

endpackage

// File: rtl/otlb_entries.sv
module otlb_entries
    import otlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 27,
    parameter int PPN_W   = 19,
    parameter int OWNER_W = 6,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [PPN_W-1:0]   lk_ppn,
    output logic [PERM_W-1:0]  lk_perm,
    output logic [OWNER_W-1:0] lk_owner,
    input  logic               inv_all,
    input  logic               ins_en,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PPN_W-1:0]   ins_ppn,
    input  logic [PERM_W-1:0]  ins_perm,
    input  logic [OWNER_W-1:0] ins_owner,
    input  logic               own_en,
    input  logic [VPN_W-1:0]   own_vpn,
    input  logic [OWNER_W-1:0] own_owner
);

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q   [ENTRIES];
    logic [PPN_W-1:0]   ppn_q   [ENTRIES];
    logic [PERM_W-1:0]  perm_q  [ENTRIES];
    logic [OWNER_W-1:0] own_q   [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] own_match;
    logic [IDX_W-1:0]   victim_q;

    // per-slot comparators
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match[gi]     = vld_q[gi] && (tag_q[gi] == lk_vpn);
        assign own_match[gi] = vld_q[gi] && (tag_q[gi] == own_vpn);
    end

    // slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                ppn_q[i]  <= '0;
                perm_q[i] <= '0;
                own_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all) begin
                    vld_q[i] <= 1'b0;
                end
                if (own_en && own_match[i]) begin
                    own_q[i] <= own_owner;
                end
                if (ins_en && (victim_q == IDX_W'(i))) begin
                    vld_q[i]  <= 1'b1;
                    tag_q[i]  <= ins_vpn;
                    ppn_q[i]  <= ins_ppn;
                    perm_q[i] <= ins_perm;
                    own_q[i]  <= ins_owner;
                end
            end
        end
    end

    // round-robin victim pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_q <= '0;
        end else if (inv_all) begin
            victim_q <= '0;
        end else if (ins_en) begin
            if (victim_q == IDX_W'(ENTRIES - 1)) begin
                victim_q <= '0;
            end else begin
                victim_q <= victim_q + 1'b1;
            end
        end
    end

    // one-hot read: at most one slot matches
    always_comb begin
        lk_hit   = |match;
        lk_ppn   = '0;
        lk_perm  = '0;
        lk_owner = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_ppn   = lk_ppn   | ({PPN_W{match[i]}}   & ppn_q[i]);
            lk_perm  = lk_perm  | ({PERM_W{match[i]}}  & perm_q[i]);
            lk_owner = lk_owner | ({OWNER_W{match[i]}} & own_q[i]);
        end
    end

endmodule

// File: rtl/otlb_steer.sv
module otlb_steer
    import otlb_pkg::*;
#(
    parameter int PPN_W     = 19,
    parameter int PAGE_BITS = 21,
    parameter int OWNER_W   = 6,
    parameter int PART_W    = 3,
    localparam int PA_W     = PPN_W + PAGE_BITS
) (
    input  logic [PPN_W-1:0]     ppn,
    input  logic [PERM_W-1:0]    perm,
    input  logic [OWNER_W-1:0]   owner,
    input  logic [1:0]           op,
    input  logic [PAGE_BITS-1:0] off,
    input  logic [OWNER_W-1:0]   core_id,
    input  logic                 abort,
    output logic [1:0]           code,
    output logic [PA_W-1:0]      paddr,
    output logic [OWNER_W-1:0]   owner_o,
    output logic                 is_local,
    output logic                 cacheable,
    output logic                 to_host,
    output logic [PART_W-1:0]    part
);

    logic permitted;

    always_comb begin
        unique case (op_e'(op))
            OP_LOAD:  permitted = perm[PERM_RD];
            OP_STORE: permitted = perm[PERM_WR];
            OP_FETCH: permitted = perm[PERM_EX];
            default:  permitted = 1'b0;
        endcase
    end

    always_comb begin
        code      = RC_ROUTE;
        paddr     = {ppn, off};
        owner_o   = owner;
        is_local  = (owner == core_id);
        cacheable = (owner == core_id);
        to_host   = (owner == '0);
        part      = ppn[PART_W-1:0];
        if (abort || !permitted) begin
            code      = abort ? RC_ABORT : RC_FAULT;
            paddr     = '0;
            owner_o   = '0;
            is_local  = 1'b0;
            cacheable = 1'b0;
            to_host   = 1'b0;
            part      = '0;
        end
    end

endmodule

// File: rtl/otlb_top.sv
module otlb_top
    import otlb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 48,
    parameter int PA_W      = 40,
    parameter int PAGE_BITS = 21,
    parameter int OWNER_W   = 6,
    parameter int PART_W    = 3,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OWNER_W-1:0] core_id,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_op,
    output logic               miss_valid,
    output logic [VPN_W-1:0]   miss_vpn,
    input  logic               fill_valid,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic [2:0]         fill_perm,
    input  logic [OWNER_W-1:0] fill_owner,
    input  logic               fill_abort,
    input  logic               own_wr_valid,
    input  logic [VPN_W-1:0]   own_wr_vpn,
    input  logic [OWNER_W-1:0] own_wr_owner,
    input  logic               inv_all,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [1:0]         rsp_code,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [OWNER_W-1:0] rsp_owner,
    output logic               rsp_local,
    output logic               rsp_cacheable,
    output logic               rsp_to_host,
    output logic [PART_W-1:0]  rsp_partition
);

    state_e st_q, st_d;

    logic [VPN_W-1:0]     pend_vpn_q;
    logic [PAGE_BITS-1:0] pend_off_q;
    logic [1:0]           pend_op_q;

    logic                 lk_hit;
    logic [PPN_W-1:0]     lk_ppn;
    logic [PERM_W-1:0]    lk_perm;
    logic [OWNER_W-1:0]   lk_owner;

    logic [PPN_W-1:0]     s_ppn;
    logic [PERM_W-1:0]    s_perm;
    logic [OWNER_W-1:0]   s_owner;
    logic [1:0]           s_op;
    logic [PAGE_BITS-1:0] s_off;
    logic                 s_abort;

    logic [1:0]           n_code;
    logic [PA_W-1:0]      n_paddr;
    logic [OWNER_W-1:0]   n_owner;
    logic                 n_local;
    logic                 n_cacheable;
    logic                 n_to_host;
    logic [PART_W-1:0]    n_part;

    logic accept;
    logic fill_take;
    logic ins_en;
    logic load_rsp;

    assign req_ready  = (st_q == ST_IDLE);
    assign miss_valid = (st_q == ST_WAIT);
    assign rsp_valid  = (st_q == ST_RESP);
    assign miss_vpn   = pend_vpn_q;

    assign accept    = req_valid && req_ready;
    assign fill_take = (st_q == ST_WAIT) && fill_valid;
    assign ins_en    = fill_take && !fill_abort;
    assign load_rsp  = (accept && lk_hit) || fill_take;

    otlb_entries #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .OWNER_W (OWNER_W)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (req_vaddr[VA_W-1:PAGE_BITS]),
        .lk_hit    (lk_hit),
        .lk_ppn    (lk_ppn),
        .lk_perm   (lk_perm),
        .lk_owner  (lk_owner),
        .inv_all   (inv_all),
        .ins_en    (ins_en),
        .ins_vpn   (pend_vpn_q),
        .ins_ppn   (fill_ppn),
        .ins_perm  (fill_perm),
        .ins_owner (fill_owner),
        .own_en    (own_wr_valid),
        .own_vpn   (own_wr_vpn),
        .own_owner (own_wr_owner)
    );

    // steering source: live lookup in IDLE, handler answer in WAIT
    always_comb begin
        if (st_q == ST_WAIT) begin
            s_ppn   = fill_ppn;
            s_perm  = fill_perm;
            s_owner = fill_owner;
            s_op    = pend_op_q;
            s_off   = pend_off_q;
            s_abort = fill_abort;
        end else begin
            s_ppn   = lk_ppn;
            s_perm  = lk_perm;
            s_owner = lk_owner;
            s_op    = req_op;
            s_off   = req_vaddr[PAGE_BITS-1:0];
            s_abort = 1'b0;
        end
    end

    otlb_steer #(
        .PPN_W     (PPN_W),
        .PAGE_BITS (PAGE_BITS),
        .OWNER_W   (OWNER_W),
        .PART_W    (PART_W)
    ) u_steer (
        .ppn       (s_ppn),
        .perm      (s_perm),
        .owner     (s_owner),
        .op        (s_op),
        .off       (s_off),
        .core_id   (core_id),
        .abort     (s_abort),
        .code      (n_code),
        .paddr     (n_paddr),
        .owner_o   (n_owner),
        .is_local  (n_local),
        .cacheable (n_cacheable),
        .to_host   (n_to_host),
        .part      (n_part)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept)     st_d = lk_hit ? ST_RESP : ST_WAIT;
            ST_WAIT: if (fill_valid) st_d = ST_RESP;
            ST_RESP: if (rsp_ready)  st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // registered outputs and pending request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vpn_q    <= '0;
            pend_off_q    <= '0;
            pend_op_q     <= '0;
            rsp_code      <= '0;
            rsp_paddr     <= '0;
            rsp_owner     <= '0;
            rsp_local     <= 1'b0;
            rsp_cacheable <= 1'b0;
            rsp_to_host   <= 1'b0;
            rsp_partition <= '0;
        end else begin
            if (accept) begin
                pend_vpn_q <= req_vaddr[VA_W-1:PAGE_BITS];
                pend_off_q <= req_vaddr[PAGE_BITS-1:0];
                pend_op_q  <= req_op;
            end
            if (load_rsp) begin
                rsp_code      <= n_code;
                rsp_paddr     <= n_paddr;
                rsp_owner     <= n_owner;
                rsp_local     <= n_local;
                rsp_cacheable <= n_cacheable;
                rsp_to_host   <= n_to_host;
                rsp_partition <= n_part;
            end
        end
    end

endmodule

// File: rtl/otlb_chk.sv
module otlb_chk #(
    parameter int VA_W      = 48,
    parameter int PA_W      = 40,
    parameter int PAGE_BITS = 21,
    parameter int OWNER_W   = 6,
    parameter int PART_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               miss_valid,
    input logic [VA_W-PAGE_BITS-1:0] miss_vpn,
    input logic               fill_valid,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [1:0]         rsp_code,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [OWNER_W-1:0] rsp_owner,
    input logic               rsp_local,
    input logic               rsp_cacheable,
    input logic               rsp_to_host,
    input logic [PART_W-1:0]  rsp_partition
);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_code) && $stable(rsp_owner) && $stable(rsp_cacheable));

    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || miss_valid) |-> !req_ready);

    p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_miss_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && !fill_valid |=> miss_valid && $stable(miss_vpn));

    p_fill_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && fill_valid |=> rsp_valid);

    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_code != 2'd0 |-> rsp_paddr == '0 && !rsp_local
            && !rsp_cacheable && !rsp_to_host);

    p_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_to_host |-> rsp_owner == '0 && !rsp_local);

    p_cache_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cacheable |-> rsp_local && rsp_code == 2'd0);

    p_part_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_partition == rsp_paddr[PAGE_BITS +: PART_W]);

endmodule

bind otlb_top otlb_chk #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .OWNER_W   (OWNER_W),
    .PART_W    (PART_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .miss_valid    (miss_valid),
    .miss_vpn      (miss_vpn),
    .fill_valid    (fill_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_code      (rsp_code),
    .rsp_paddr     (rsp_paddr),
    .rsp_owner     (rsp_owner),
    .rsp_local     (rsp_local),
    .rsp_cacheable (rsp_cacheable),
    .rsp_to_host   (rsp_to_host),
    .rsp_partition (rsp_partition)
);

// File: tb/sim_otlb_top.sv
`timescale 1ns/1ps
module sim_otlb_top;

    localparam int CORE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  core_id = 6'(CORE);
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_op = '0;
    logic        miss_valid;
    logic [26:0] miss_vpn;
    logic        fill_valid = 1'b0;
    logic [18:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic [5:0]  fill_owner = '0;
    logic        fill_abort = 1'b0;
    logic        own_wr_valid = 1'b0;
    logic [26:0] own_wr_vpn = '0;
    logic [5:0]  own_wr_owner = '0;
    logic        inv_all = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_code;
    logic [39:0] rsp_paddr;
    logic [5:0]  rsp_owner;
    logic        rsp_local;
    logic        rsp_cacheable;
    logic        rsp_to_host;
    logic [2:0]  rsp_partition;

    always #10 clk = ~clk;

    otlb_top u0 (
        .clk(clk), .rst_n(rst_n), .core_id(core_id),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_op(req_op),
        .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .fill_owner(fill_owner), .fill_abort(fill_abort),
        .own_wr_valid(own_wr_valid), .own_wr_vpn(own_wr_vpn), .own_wr_owner(own_wr_owner),
        .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
        .rsp_paddr(rsp_paddr), .rsp_owner(rsp_owner), .rsp_local(rsp_local),
        .rsp_cacheable(rsp_cacheable), .rsp_to_host(rsp_to_host), .rsp_partition(rsp_partition)
    );

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [26:0] vpn;
        logic [18:0] ppn;
        logic [2:0]  perm;
        logic [5:0]  owner;
        logic [1:0]  op;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{27'h10,      19'h00003, 3'b001, 6'd5,  2'd0},
        '{27'h11,      19'h0010A, 3'b011, 6'd9,  2'd1},
        '{27'h12,      19'h7FFFF, 3'b001, 6'd0,  2'd1},
        '{27'h13,      19'h00045, 3'b100, 6'd0,  2'd2},
        '{27'h14,      19'h00001, 3'b011, 6'd5,  2'd0},
        '{27'h7FFFFFF, 19'h12346, 3'b111, 6'd63, 2'd2},
        '{27'h15,      19'h00002, 3'b111, 6'd5,  2'd3},
        '{27'h16,      19'h00008, 3'b010, 6'd5,  2'd0}
    };

    logic        g_miss;
    logic [26:0] g_mvpn;
    logic        g_rv;
    logic [1:0]  g_code;
    logic [39:0] g_paddr;
    logic [5:0]  g_owner;
    logic        g_local, g_cache, g_host;
    logic [2:0]  g_part;
    logic        g_ready_after;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [47:0] va, input logic [1:0] op,
                          input logic [18:0] fppn, input logic [2:0] fperm,
                          input logic [5:0] fown, input logic fab, input int stall);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_op = op;
        @(negedge clk);
        req_valid = 1'b0;
        g_miss = miss_valid;
        g_mvpn = miss_vpn;
        if (miss_valid) begin
            fill_valid = 1'b1; fill_ppn = fppn; fill_perm = fperm;
            fill_owner = fown; fill_abort = fab;
            @(negedge clk);
            fill_valid = 1'b0; fill_abort = 1'b0;
        end
        g_rv = rsp_valid; g_code = rsp_code; g_paddr = rsp_paddr; g_owner = rsp_owner;
        g_local = rsp_local; g_cache = rsp_cacheable; g_host = rsp_to_host; g_part = rsp_partition;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == g_paddr && rsp_code == g_code, "R12 held", {23'd0, rsp_valid, rsp_paddr}, {23'd0, 1'b1, g_paddr});
            chk(!req_ready, "R12 ready low", 64'(req_ready), 64'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        g_ready_after = req_ready;
    endtask

    function automatic bit allowed(input logic [1:0] op, input logic [2:0] perm);
        case (op)
            2'd0: return perm[0];
            2'd1: return perm[1];
            2'd2: return perm[2];
            default: return 1'b0;
        endcase
    endfunction

    task automatic expect_rsp(input string tag, input logic [18:0] ppn, input logic [20:0] off,
                              input logic [2:0] perm, input logic [5:0] own, input logic [1:0] op);
        bit ok;
        logic [1:0]  e_code;
        logic [39:0] e_pa;
        logic [5:0]  e_own;
        logic        e_loc, e_host;
        logic [2:0]  e_part;
        ok     = allowed(op, perm);
        e_code = ok ? 2'd0 : 2'd1;
        e_pa   = ok ? {ppn, off} : 40'd0;
        e_own  = ok ? own : 6'd0;
        e_loc  = ok && (own == 6'(CORE));
        e_host = ok && (own == 6'd0);
        e_part = ok ? ppn[2:0] : 3'd0;
        chk(g_rv, {tag, " R2 rsp_valid"}, 64'(g_rv), 64'd1);
        chk(g_code == e_code, {tag, " R5 code"}, 64'(g_code), 64'(e_code));
        chk(g_paddr == e_pa, {tag, " R2 paddr"}, 64'(g_paddr), 64'(e_pa));
        chk(g_owner == e_own, {tag, " R6 owner"}, 64'(g_owner), 64'(e_own));
        chk(g_local == e_loc, {tag, " R6 local"}, 64'(g_local), 64'(e_loc));
        chk(g_host == e_host, {tag, " R6 host"}, 64'(g_host), 64'(e_host));
        chk(g_cache == e_loc, {tag, " R7 cacheable"}, 64'(g_cache), 64'(e_loc));
        chk(g_part == e_part, {tag, " R8 partition"}, 64'(g_part), 64'(e_part));
        chk(g_ready_after, {tag, " R12 ready after drain"}, 64'(g_ready_after), 64'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [20:0] off;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready, "R1 req_ready", 64'(req_ready), 64'd1);
        chk(!rsp_valid, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(!miss_valid, "R1 miss_valid", 64'(miss_valid), 64'd0);

        // table walk: first touch misses (R1, R3), second touch hits (R2)
        for (int i = 0; i < 8; i++) begin
            off = 21'h1F0F0 + 21'(i * 37);
            access({VECS[i].vpn, off}, VECS[i].op, VECS[i].ppn, VECS[i].perm, VECS[i].owner, 1'b0, 0);
            chk(g_miss, "R3 first touch miss", 64'(g_miss), 64'd1);
            chk(g_mvpn == VECS[i].vpn, "R3 miss_vpn", 64'(g_mvpn), 64'(VECS[i].vpn));
            expect_rsp("R3 fill", VECS[i].ppn, off, VECS[i].perm, VECS[i].owner, VECS[i].op);
            access({VECS[i].vpn, off}, VECS[i].op, '0, '0, '0, 1'b0, 0);
            chk(!g_miss, "R3 refill hit", 64'(g_miss), 64'd0);
            expect_rsp("R2 hit", VECS[i].ppn, off, VECS[i].perm, VECS[i].owner, VECS[i].op);
        end

        // R4 abort
        access({27'h30, 21'h00010}, 2'd0, 19'h00055, 3'b111, 6'd5, 1'b1, 0);
        chk(g_code == 2'd2, "R4 abort code", 64'(g_code), 64'd2);
        chk(g_paddr == 40'd0, "R4 abort paddr", 64'(g_paddr), 64'd0);
        access({27'h30, 21'h00010}, 2'd0, 19'h00055, 3'b001, 6'd5, 1'b0, 0);
        chk(g_miss, "R4 no install after abort", 64'(g_miss), 64'd1);

        // R9 owner retarget of cached page
        @(negedge clk);
        own_wr_valid = 1'b1; own_wr_vpn = 27'h11; own_wr_owner = 6'd5;
        @(negedge clk);
        own_wr_valid = 1'b0;
        access({27'h11, 21'h00400}, 2'd1, '0, '0, '0, 1'b0, 0);
        chk(!g_miss, "R9 retarget still hit", 64'(g_miss), 64'd0);
        expect_rsp("R9 retarget", 19'h0010A, 21'h00400, 3'b011, 6'd5, 2'd1);
        // R9 owner write to absent page
        @(negedge clk);
        own_wr_valid = 1'b1; own_wr_vpn = 27'h40; own_wr_owner = 6'd7;
        @(negedge clk);
        own_wr_valid = 1'b0;
        access({27'h40, 21'h0}, 2'd0, 19'h00020, 3'b001, 6'd2, 1'b0, 0);
        chk(g_miss, "R9 absent write no install", 64'(g_miss), 64'd1);
        chk(g_owner == 6'd2, "R9 absent owner from fill", 64'(g_owner), 64'd2);

        // R11 invalidate all
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        access({27'h10, 21'h0}, 2'd0, 19'h00003, 3'b001, 6'd5, 1'b0, 0);
        chk(g_miss, "R11 miss after invalidate", 64'(g_miss), 64'd1);

        // fill remaining slots (R10)
        for (int k = 1; k < 16; k++) begin
            access({27'h100 + 27'(k), 21'h0}, 2'd0, 19'(k), 3'b111, 6'd1, 1'b0, 0);
        end

        // R13 stray fill with table full
        @(negedge clk);
        fill_valid = 1'b1; fill_ppn = 19'h7AAAA; fill_perm = 3'b111; fill_owner = 6'd3;
        @(negedge clk);
        fill_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_valid, "R13 no response", 64'(rsp_valid), 64'd0);
        chk(!miss_valid && req_ready, "R13 idle kept", 64'(req_ready), 64'd1);
        access({27'h10, 21'h00077}, 2'd0, '0, '0, '0, 1'b0, 0);
        chk(!g_miss, "R13 entry untouched", 64'(g_miss), 64'd0);
        chk(g_paddr == {19'h00003, 21'h00077}, "R13 paddr", 64'(g_paddr), 64'({19'h00003, 21'h00077}));

        // R10 round robin eviction of slot 0
        access({27'h200, 21'h0}, 2'd0, 19'h00009, 3'b001, 6'd5, 1'b0, 0);
        chk(g_miss, "R10 new page miss", 64'(g_miss), 64'd1);
        access({27'h101, 21'h0}, 2'd0, '0, '0, '0, 1'b0, 0);
        chk(!g_miss, "R10 neighbour kept", 64'(g_miss), 64'd0);
        access({27'h10, 21'h0}, 2'd0, 19'h00003, 3'b001, 6'd5, 1'b0, 0);
        chk(g_miss, "R10 oldest evicted", 64'(g_miss), 64'd1);

        // R12 stalled consumer
        access({27'h102, 21'h00123}, 2'd0, '0, '0, '0, 1'b0, 3);
        chk(!g_miss, "R12 hit", 64'(g_miss), 64'd0);
        expect_rsp("R12 stalled", 19'd2, 21'h00123, 3'b111, 6'd1, 2'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule